// File: doc/BRIEF.md
# Pausable SPI Flash Stream Reader

This block reads a sequential run of bytes from a serial flash and places them in a small receive queue. An audio co-processor drains that queue one byte at a time. It can stream compressed samples without help from a general DMA engine. Software programs a start address and a byte count through four word registers, then writes a start command. The block sends a read command, shifts the data in and stops once the count is used up.

Software can pause the stream at any time. The block finishes the byte it is shifting, raises chip select and hands the three output pins back to software-owned register bits. Software can then use the same wires for other work, such as clocking a button shift register. A resume command sends a fresh read command at the next byte that was not fetched, so no byte is lost or repeated. Ownership of the pins changes hands only while chip select is high on both sides of the switch.

Top module: `spi_stream_reader`

## Requirements
- R1: Each bus session sends command byte 0x03 and then a 24-bit byte address, most significant bit first, in SPI mode 0. SCK idles low, MOSI changes only while SCK is low, and MISO is sampled while SCK is high.
- R2: Data bytes (MSB first) enter an 8-entry FIFO in address order. `fifo_rdata` shows the oldest byte and `fifo_valid` is high when the FIFO holds any byte. A `fifo_pop` pulse removes the oldest byte. A pop on an empty FIFO has no effect.
- R3: When the FIFO holds 8 bytes, no new byte is started, SCK stays low and chip select stays asserted. Clocking resumes after a pop, and the FIFO never overflows.
- R4: The remaining count drops by one per received byte. When it reaches zero, the block raises chip select, sets done and clears busy. A start with length 0 sets done at once, with no bus activity.
- R5: A start written while busy is ignored, and the running stream carries on unchanged.
- R6: A pause takes effect only between bytes. The block raises chip select, releases the pins and then reports paused (busy stays high).
- R7: Offset 3 holds the software pin bits: bit0 SCK, bit1 chip select (active low), bit2 MOSI. Reading it returns those bits, with the live MISO level in bit3. While the block does not own the pins, the pins follow these bits.
- R8: A resume while paused sends a new read command at the address of the next byte not yet fetched. Across the pause, the received bytes form one unbroken sequence.
- R9: The block takes or releases the pins only while the software chip-select bit is high. It waits in place until that bit is high. SPI chip select is high in the cycle before and the cycle of every switch.
- R10: Offset 0 reads status: bit0 busy, bit1 paused, bit2 done, bits[7:4] FIFO level, bits[31:8] next fetch address. All of these are zero after reset.
- R11: Writes to offset 0 are commands: bit0 start, bit1 pause, bit2 resume. Offset 1 holds the start address. Offset 2 takes the length on write and reads back the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| fifo_pop | input | 1 | Remove the oldest byte |
| fifo_rdata | output | 8 | Oldest byte in the FIFO |
| fifo_valid | output | 1 | FIFO not empty |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to flash |
| spi_miso | input | 1 | SPI data from flash |

## Verification
Assertions watch four things in every cycle:
- MOSI stays still while the block drives SCK high.
- The FIFO level never passes its depth, and no byte is pushed into a full FIFO.
- Chip select rises under the block's control only at a byte boundary with SCK low.
- Every change of pin ownership happens with chip select high before and after.

Only the bench scenarios can show the rest:
- The command and address the flash actually sees on each session.
- That the bytes received before and after a pause join into one unbroken sequence.
- That the block holds off while software keeps chip select low.
- That a second start during a stream is ignored.

// File: rtl/spi_stream_reader.sv
module spi_stream_reader #(
  parameter int AW = 24,
  parameter int FIFO_LOG2 = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        fifo_pop,
  output logic [7:0]  fifo_rdata,
  output logic        fifo_valid,
  output logic        spi_sck,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  localparam int DEPTH = 1 << FIFO_LOG2;
  localparam int CW = FIFO_LOG2 + 1;
  localparam int SW = AW + 8;

  typedef enum logic [2:0] {S_IDLE, S_GRAB, S_CMD, S_DATA, S_REL, S_PAUSED} state_t;
  state_t state;

  logic own, sck_q, cs_q, mosi_q, ph, pause_req, done_q;
  logic sw_sck, sw_cs_n, sw_mosi;
  logic [5:0] cnt;
  logic [SW-1:0] sh;
  logic [7:0] rx;
  logic [AW-1:0] start_q, len_q, addr_q, rem_q;

  logic [7:0] mem [DEPTH];
  logic [FIFO_LOG2-1:0] wp, rp;
  logic [CW-1:0] level;

  wire ctrl_we  = reg_we && reg_addr == 2'd0;
  wire start_w  = ctrl_we && reg_wdata[0];
  wire pause_w  = ctrl_we && reg_wdata[1];
  wire resume_w = ctrl_we && reg_wdata[2];
  wire full     = level == CW'(DEPTH);
  wire pop      = fifo_pop && level != '0;
  wire push     = state == S_DATA && ph && cnt == 6'd0;
  wire [7:0] push_data = {rx[6:0], spi_miso};
  wire busy     = state != S_IDLE;
  wire paused   = state == S_PAUSED;
  wire live     = state == S_GRAB || state == S_CMD || state == S_DATA;

  assign spi_sck  = own ? sck_q  : sw_sck;
  assign spi_cs_n = own ? cs_q   : sw_cs_n;
  assign spi_mosi = own ? mosi_q : sw_mosi;
  assign fifo_rdata = mem[rp];
  assign fifo_valid = level != '0;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = 32'({addr_q, 4'(level), 1'b0, done_q, paused, busy});
      2'd1:    reg_rdata = 32'(start_q);
      2'd2:    reg_rdata = 32'(rem_q);
      default: reg_rdata = {28'd0, spi_miso, sw_mosi, sw_cs_n, sw_sck};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      level <= '0;
    end else begin
      if (push) begin
        mem[wp] <= push_data;
        wp <= wp + 1'b1;
      end
      if (pop) rp <= rp + 1'b1;
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      own <= 1'b0; sck_q <= 1'b0; cs_q <= 1'b1; mosi_q <= 1'b0; ph <= 1'b0;
      pause_req <= 1'b0; done_q <= 1'b0;
      sw_sck <= 1'b0; sw_cs_n <= 1'b1; sw_mosi <= 1'b0;
      cnt <= '0; sh <= '0; rx <= '0;
      start_q <= '0; len_q <= '0; addr_q <= '0; rem_q <= '0;
    end else begin
      if (reg_we && reg_addr == 2'd1) start_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == 2'd2) len_q <= reg_wdata[AW-1:0];
      if (reg_we && reg_addr == 2'd3) {sw_mosi, sw_cs_n, sw_sck} <= reg_wdata[2:0];
      if (pause_w && live) pause_req <= 1'b1;

      case (state)
        S_IDLE: if (start_w) begin
          addr_q <= start_q;
          rem_q <= len_q;
          done_q <= len_q == '0;
          if (len_q != '0) state <= S_GRAB;
        end
        S_GRAB: begin
          if (!own) begin
            if (pause_req || pause_w) begin
              pause_req <= 1'b0;
              state <= S_PAUSED;
            end else if (sw_cs_n) begin
              own <= 1'b1;
              cs_q <= 1'b1;
              sck_q <= 1'b0;
            end
          end else begin
            cs_q <= 1'b0;
            sh <= {8'h03, addr_q};
            mosi_q <= 1'b0;
            ph <= 1'b0;
            cnt <= 6'(SW - 1);
            state <= S_CMD;
          end
        end
        S_CMD: begin
          if (!ph) begin
            sck_q <= 1'b1;
            ph <= 1'b1;
          end else begin
            sck_q <= 1'b0;
            ph <= 1'b0;
            if (cnt == 6'd0) begin
              cnt <= 6'd7;
              state <= S_DATA;
            end else begin
              cnt <= cnt - 1'b1;
              sh <= sh << 1;
              mosi_q <= sh[SW-2];
            end
          end
        end
        S_DATA: begin
          if (!ph) begin
            if (cnt == 6'd7 && pause_req) begin
              cs_q <= 1'b1;
              state <= S_REL;
            end else if (!(cnt == 6'd7 && full)) begin
              sck_q <= 1'b1;
              ph <= 1'b1;
            end
          end else begin
            sck_q <= 1'b0;
            ph <= 1'b0;
            rx <= push_data;
            if (cnt == 6'd0) begin
              cnt <= 6'd7;
              addr_q <= addr_q + 1'b1;
              rem_q <= rem_q - 1'b1;
              if (rem_q == AW'(1)) begin
                cs_q <= 1'b1;
                state <= S_REL;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        S_REL: if (sw_cs_n) begin
          own <= 1'b0;
          pause_req <= 1'b0;
          if (rem_q == '0) begin
            done_q <= 1'b1;
            state <= S_IDLE;
          end else begin
            state <= S_PAUSED;
          end
        end
        S_PAUSED: if (resume_w) state <= S_GRAB;
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r1_mosi_still_while_sck_high: assert property (@(posedge clk) disable iff (!rst_n)
    (own && spi_sck) |-> $stable(spi_mosi));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !push);

  a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));

  a_r6_cs_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (own && $rose(spi_cs_n)) |-> (cnt == 6'd7 && !spi_sck));

  a_r9_switch_with_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(own) |-> (spi_cs_n && $past(spi_cs_n)));

  a_r4_done_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy);
endmodule

// File: tb/spi_stream_reader_test.sv
module spi_stream_reader_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fifo_pop = 1'b0, fifo_valid;
  logic [7:0] fifo_rdata;
  logic spi_sck, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0, fails = 0, cycles = 0;

  spi_stream_reader uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fifo_pop(fifo_pop),
    .fifo_rdata(fifo_rdata), .fifo_valid(fifo_valid), .spi_sck(spi_sck),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso));

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails);
      $finish;
    end
  end

  // flash model: mode 0, read command only
  int bitcnt = 0;
  int nsess = 0;
  logic [31:0] sr = '0;
  logic [23:0] base = '0;
  logic [7:0]  cmd_log [8];
  logic [23:0] addr_log [8];

  function automatic logic [7:0] fdat(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  always @(posedge spi_sck or posedge spi_cs_n) begin
    if (spi_cs_n) bitcnt = 0;
    else begin
      if (bitcnt < 32) sr = {sr[30:0], spi_mosi};
      bitcnt++;
      if (bitcnt == 32) begin
        cmd_log[nsess % 8] = sr[31:24];
        addr_log[nsess % 8] = sr[23:0];
        base = sr[23:0];
        nsess++;
      end
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && bitcnt >= 32) begin
      automatic int idx = bitcnt - 32;
      automatic logic [7:0] b = fdat(base + 24'(idx / 8));
      spi_miso = b[7 - (idx % 8)];
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = 2'd0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #0.5 d = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic pop_byte(output logic [7:0] b);
    @(negedge clk);
    while (!fifo_valid) @(negedge clk);
    b = fifo_rdata;
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
  endtask

  task automatic wait_bit(input int bitpos);
    logic [31:0] s;
    for (int i = 0; i < 20000; i++) begin
      rd(2'd0, s);
      if (s[bitpos]) return;
    end
    check("wait status bit", 32'(bitpos), 32'hFFFF_FFFF);
  endtask

  task automatic t_reset;
    logic [31:0] s;
    rd(2'd0, s);
    check("R10 status after reset", s, 32'h0);
    check("R7 pins follow software reset bits", {spi_mosi, spi_cs_n, spi_sck}, 3'b010);
    check("R2 fifo empty after reset", fifo_valid, 1'b0);
  endtask

  task automatic t_stream;
    logic [31:0] s;
    logic [7:0] b;
    int n0 = nsess;
    wr(2'd1, 32'h001230);
    wr(2'd2, 32'd5);
    wr(2'd0, 32'h1);
    for (int i = 0; i < 5; i++) begin
      pop_byte(b);
      check("R2 byte order", b, fdat(24'h001230 + 24'(i)));
    end
    wait_bit(2);
    rd(2'd0, s);
    check("R4 done, not busy, address advanced", s, {24'h001235, 8'h04});
    check("R1 command byte", cmd_log[n0 % 8], 8'h03);
    check("R1 address sent", addr_log[n0 % 8], 24'h001230);
    check("R4 chip select high at end", spi_cs_n, 1'b1);
    rd(2'd2, s);
    check("R11 remaining count reads zero", s, 32'd0);
  endtask

  task automatic t_fifo_full;
    logic [31:0] s;
    logic [7:0] b;
    logic sck0;
    wr(2'd1, 32'h000100);
    wr(2'd2, 32'd12);
    wr(2'd0, 32'h1);
    repeat (400) @(negedge clk);
    rd(2'd0, s);
    check("R3 level 8 and busy when full", s[7:0], 8'h81);
    check("R3 fetch address stopped at 8 bytes", s[31:8], 32'h000108);
    sck0 = 1'b0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      sck0 = sck0 | spi_sck;
    end
    check("R3 sck held low while full", sck0, 1'b0);
    check("R3 chip select still asserted", spi_cs_n, 1'b0);
    for (int i = 0; i < 12; i++) begin
      pop_byte(b);
      check("R3 bytes intact after stall", b, fdat(24'h000100 + 24'(i)));
    end
    wait_bit(2);
  endtask

  task automatic t_pause;
    logic [31:0] s;
    logic [7:0] b;
    logic [23:0] resume_at;
    int n0, n1, got;
    got = 0;
    n0 = nsess;
    wr(2'd1, 32'h00A0F8);
    wr(2'd2, 32'd20);
    wr(2'd0, 32'h1);
    for (int i = 0; i < 3; i++) begin
      pop_byte(b);
      check("R2 byte before pause", b, fdat(24'h00A0F8 + 24'(i)));
      got++;
    end
    wr(2'd0, 32'h2);
    wait_bit(1);
    rd(2'd0, s);
    check("R6 paused and busy", s[2:0], 3'b011);
    resume_at = s[31:8];
    check("R6 whole bytes only", 32'(resume_at - 24'h00A0F8), 32'(got) + 32'(s[7:4]));
    check("R6 chip select high when paused", spi_cs_n, 1'b1);
    wr(2'd3, 32'h7);
    check("R7 pins follow software bits", {spi_mosi, spi_cs_n, spi_sck}, 3'b111);
    rd(2'd3, s);
    check("R7 pin register read back", s[2:0], 3'b111);
    wr(2'd3, 32'h0);
    wr(2'd0, 32'h4);
    n1 = nsess;
    repeat (40) @(negedge clk);
    check("R9 no takeover while software holds cs low", nsess, n1);
    check("R9 pins still software-driven", {spi_mosi, spi_cs_n, spi_sck}, 3'b000);
    wr(2'd3, 32'h2);
    while (got < 20) begin
      pop_byte(b);
      check("R8 unbroken sequence", b, fdat(24'h00A0F8 + 24'(got)));
      got++;
    end
    wait_bit(2);
    check("R8 one extra session", nsess, n0 + 2);
    check("R8 resume address", addr_log[(n0 + 1) % 8], resume_at);
    check("R8 resume command", cmd_log[(n0 + 1) % 8], 8'h03);
  endtask

  task automatic t_start_busy;
    logic [7:0] b;
    logic [31:0] s;
    int n0 = nsess;
    wr(2'd1, 32'h000200);
    wr(2'd2, 32'd6);
    wr(2'd0, 32'h1);
    wr(2'd1, 32'h000300);
    wr(2'd0, 32'h1);
    for (int i = 0; i < 6; i++) begin
      pop_byte(b);
      check("R5 stream unchanged by second start", b, fdat(24'h000200 + 24'(i)));
    end
    wait_bit(2);
    repeat (40) @(negedge clk);
    check("R5 only one session", nsess, n0 + 1);
    rd(2'd0, s);
    check("R5 end address", s[31:8], 32'h000206);
  endtask

  task automatic t_zero_and_empty;
    logic [31:0] s;
    int n0 = nsess;
    wr(2'd2, 32'd0);
    wr(2'd0, 32'h1);
    rd(2'd0, s);
    check("R4 zero length done at once", s[2:0], 3'b100);
    repeat (30) @(negedge clk);
    check("R4 zero length no bus activity", nsess, n0);
    fifo_pop = 1'b1;
    @(negedge clk);
    fifo_pop = 1'b0;
    rd(2'd0, s);
    check("R2 pop on empty keeps level", s[7:4], 4'd0);
    check("R2 still empty", fifo_valid, 1'b0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_stream();
    t_fifo_full();
    t_pause();
    t_start_busy();
    t_zero_and_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule